// File: doc/BRIEF.md
# Four-Agent MESI Line-State Tracker

This block keeps the MESI coherence state of a single cache line as seen by four processor caches that snoop a shared bus. It takes one transaction per strobe: the number of the requesting cache and a flag that selects store or load. From the current four states it works out the bus operation the transaction needs. It also works out which party supplies the line: memory or one particular peer cache. It then updates every cache's state together.

It is used as the coherence decision point in a bus-based multiprocessor model, or as a checking reference for one. The results are registered. They appear one cycle after the strobe, together with a response-valid pulse. The block models no data values, no arbitration, no eviction and only one line.

Top module: `mesi_line_tracker`

## Requirements
- R1: After reset every cache is Invalid, encoded 0, in `state_o[2k+1:2k]` for cache k. The state codes are I=0, S=1, E=2, M=3. After reset `rsp_valid_o`, `bus_op_o`, `sup_kind_o`, `sup_id_o` and `wb_o` are all 0.
- R2: A load by a cache in S, E or M is a hit. It reports bus operation none (0) and supplier none (0), and it changes no state.
- R3: A load by an Invalid cache when no other cache holds the line reports bus Read (1) and supplier memory (1), and leaves the requester in E.
- R4: A load by an Invalid cache when another cache holds E or M reports bus Read with supplier peer (2). `sup_id_o` carries the holder's number, and holder and requester both end in S. `wb_o` is 1 exactly when that holder was in M.
- R5: A load by an Invalid cache when only Shared copies exist reports bus Read. The lowest-numbered Shared holder is reported as the peer supplier, and the requester enters S.
- R6: A store by a cache in M reports bus none and changes nothing. A store by a cache in E reports bus none and moves the requester to M.
- R7: A store by a cache in S or I reports Read-Exclusive (2). The requester ends in M and every other cache ends in I. The supplier is the other E or M holder if there is one. Failing that, it is the lowest-numbered other S holder. Failing that, it is memory. `wb_o` stays 0.
- R8: `rsp_valid_o` is 1 for exactly the cycle after each request strobe. In any other cycle `bus_op_o`, `sup_kind_o`, `sup_id_o` and `wb_o` are 0 and the states hold.
- R9: At no time is more than one cache in E or M. A cache in E or M never coexists with an S copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one transaction per cycle it is high |
| req_id_i | input | 2 | Number of the requesting cache |
| req_store_i | input | 1 | 1 = store, 0 = load |
| state_o | output | 8 | Per-cache line state, 2 bits per cache |
| rsp_valid_o | output | 1 | Response valid, the cycle after a strobe |
| bus_op_o | output | 2 | 0 none, 1 Read, 2 Read-Exclusive |
| sup_kind_o | output | 2 | 0 none, 1 memory, 2 peer cache |
| sup_id_o | output | 2 | Supplying cache number when the supplier is a peer, else 0 |
| wb_o | output | 1 | Former Modified owner writes the line back to memory |

## Verification
Every result is captured at the clock edge that samples the strobe. `rsp_valid_o`, the bus operation, the supplier, the write-back flag and the new states are therefore all due one cycle after the request. The bench drives each request on a falling edge and drops the strobe on the next falling edge. It compares all outputs against its own model at that point, half a cycle after the capturing edge. Idle cycles are checked in the same way one cycle later, to confirm that the responses go to zero and the states hold. The sweep covers every sequence of four operations from reset, followed by a long pseudo-random run.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {BUS_NONE = 2'd0, BUS_RD = 2'd1, BUS_RDX = 2'd2} bus_op_e;
  typedef enum logic [1:0] {SUP_NONE = 2'd0, SUP_MEM = 2'd1, SUP_PEER = 2'd2} sup_e;
endpackage

// File: rtl/mesi_lowest.sv
module mesi_lowest #(
  parameter int N   = 4,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   vec_i,
  output logic           found_o,
  output logic [IDW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[k]) begin
        found_o = 1'b1;
        idx_o   = IDW'(k);
      end
    end
  end
endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop #(
  parameter int N   = 4,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][1:0] st_i,
  input  logic [IDW-1:0]    req_id_i,
  output logic              own_found_o,
  output logic [IDW-1:0]    own_idx_o,
  output logic              shr_found_o,
  output logic [IDW-1:0]    shr_idx_o
);
  import mesi_pkg::*;
  logic [N-1:0] own_vec, shr_vec;

  // holders among the peers, requester masked out
  for (genvar k = 0; k < N; k++) begin : g_peer
    logic is_peer;
    assign is_peer    = (req_id_i != IDW'(k));
    assign own_vec[k] = is_peer && (st_i[k] == ST_E || st_i[k] == ST_M);
    assign shr_vec[k] = is_peer && (st_i[k] == ST_S);
  end

  mesi_lowest #(.N(N), .IDW(IDW)) u_own (
    .vec_i(own_vec), .found_o(own_found_o), .idx_o(own_idx_o)
  );
  mesi_lowest #(.N(N), .IDW(IDW)) u_shr (
    .vec_i(shr_vec), .found_o(shr_found_o), .idx_o(shr_idx_o)
  );
endmodule

// File: rtl/mesi_decide.sv
module mesi_decide #(
  parameter int N   = 4,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][1:0] st_i,
  input  logic [IDW-1:0]    req_id_i,
  input  logic              store_i,
  input  logic              own_found_i,
  input  logic [IDW-1:0]    own_idx_i,
  input  logic              shr_found_i,
  input  logic [IDW-1:0]    shr_idx_i,
  output logic [N-1:0][1:0] nxt_o,
  output logic [1:0]        bus_o,
  output logic [1:0]        sk_o,
  output logic [IDW-1:0]    sid_o,
  output logic              wb_o
);
  import mesi_pkg::*;
  logic [1:0] req_st;
  assign req_st = st_i[req_id_i];

  always_comb begin
    nxt_o = st_i;
    bus_o = BUS_NONE;
    sk_o  = SUP_NONE;
    sid_o = '0;
    wb_o  = 1'b0;
    if (!store_i) begin
      if (req_st == ST_I) begin
        bus_o = BUS_RD;
        if (own_found_i) begin
          sk_o             = SUP_PEER;
          sid_o            = own_idx_i;
          wb_o             = (st_i[own_idx_i] == ST_M);
          nxt_o[own_idx_i] = ST_S;
          nxt_o[req_id_i]  = ST_S;
        end else if (shr_found_i) begin
          sk_o            = SUP_PEER;
          sid_o           = shr_idx_i;
          nxt_o[req_id_i] = ST_S;
        end else begin
          sk_o            = SUP_MEM;
          nxt_o[req_id_i] = ST_E;
        end
      end
    end else begin
      if (req_st == ST_E) begin
        nxt_o[req_id_i] = ST_M;
      end else if (req_st != ST_M) begin
        bus_o = BUS_RDX;
        if (own_found_i) begin
          sk_o  = SUP_PEER;
          sid_o = own_idx_i;
        end else if (shr_found_i) begin
          sk_o  = SUP_PEER;
          sid_o = shr_idx_i;
        end else begin
          sk_o = SUP_MEM;
        end
        for (int k = 0; k < N; k++) nxt_o[k] = ST_I;
        nxt_o[req_id_i] = ST_M;
      end
    end
  end
endmodule

// File: rtl/mesi_line_tracker.sv
module mesi_line_tracker #(
  parameter int N   = 4,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [IDW-1:0] req_id_i,
  input  logic           req_store_i,
  output logic [2*N-1:0] state_o,
  output logic           rsp_valid_o,
  output logic [1:0]     bus_op_o,
  output logic [1:0]     sup_kind_o,
  output logic [IDW-1:0] sup_id_o,
  output logic           wb_o
);
  logic [N-1:0][1:0] st_q, st_d;
  logic              own_found, shr_found;
  logic [IDW-1:0]    own_idx, shr_idx, sid_d;
  logic [1:0]        bus_d, sk_d;
  logic              wb_d;

  mesi_snoop #(.N(N), .IDW(IDW)) u_snoop (
    .st_i(st_q), .req_id_i(req_id_i),
    .own_found_o(own_found), .own_idx_o(own_idx),
    .shr_found_o(shr_found), .shr_idx_o(shr_idx)
  );

  mesi_decide #(.N(N), .IDW(IDW)) u_decide (
    .st_i(st_q), .req_id_i(req_id_i), .store_i(req_store_i),
    .own_found_i(own_found), .own_idx_i(own_idx),
    .shr_found_i(shr_found), .shr_idx_i(shr_idx),
    .nxt_o(st_d), .bus_o(bus_d), .sk_o(sk_d), .sid_o(sid_d), .wb_o(wb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= '0;
      rsp_valid_o <= 1'b0;
      bus_op_o    <= '0;
      sup_kind_o  <= '0;
      sup_id_o    <= '0;
      wb_o        <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        st_q       <= st_d;
        bus_op_o   <= bus_d;
        sup_kind_o <= sk_d;
        sup_id_o   <= sid_d;
        wb_o       <= wb_d;
      end else begin
        bus_op_o   <= '0;
        sup_kind_o <= '0;
        sup_id_o   <= '0;
        wb_o       <= 1'b0;
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/mesi_line_tracker_chk.sv
module mesi_line_tracker_chk #(
  parameter int N   = 4,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic [IDW-1:0] req_id_i,
  input logic           req_store_i,
  input logic [2*N-1:0] state_o,
  input logic           rsp_valid_o,
  input logic [1:0]     bus_op_o,
  input logic [1:0]     sup_kind_o,
  input logic [IDW-1:0] sup_id_o,
  input logic           wb_o
);
  int   n_owner;
  logic any_shr;
  always_comb begin
    n_owner = 0;
    any_shr = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (state_o[2*k+1]) n_owner++;
      if (state_o[2*k+:2] == 2'd1) any_shr = 1'b1;
    end
  end

  p_single_owner_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_owner <= 1) && !(n_owner == 1 && any_shr));

  p_rsp_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_rsp_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && $stable(state_o) && bus_op_o == 2'd0
                     && sup_kind_o == 2'd0 && !wb_o);

  p_store_owns_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_store_i |=> state_o[2*$past(req_id_i)+:2] == 2'd3);

  p_load_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_store_i |=> state_o[2*$past(req_id_i)+:2] != 2'd0);

  p_hit_no_supply_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && bus_op_o == 2'd0 |-> sup_kind_o == 2'd0);

  p_wb_on_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> bus_op_o == 2'd1 && sup_kind_o == 2'd2);

  p_peer_not_self_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> sup_kind_o != 2'd2 || sup_id_o != $past(req_id_i));
endmodule

bind mesi_line_tracker mesi_line_tracker_chk #(.N(N), .IDW(IDW)) u_chk (.*);

// File: tb/mesi_line_tracker_bench.sv
module mesi_line_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_id = '0;
  logic       req_store = 1'b0;
  logic [7:0] state;
  logic       rsp_valid, wb;
  logic [1:0] bus_op, sup_kind, sup_id;

  int checks = 0, errors = 0;
  int ms[4];

  always #2.5 clk = ~clk;

  mesi_line_tracker u_mesi_line_tracker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_id_i(req_id),
    .req_store_i(req_store), .state_o(state), .rsp_valid_o(rsp_valid),
    .bus_op_o(bus_op), .sup_kind_o(sup_kind), .sup_id_o(sup_id), .wb_o(wb)
  );

  function automatic logic [7:0] pack_model();
    logic [7:0] v;
    for (int k = 0; k < 4; k++) v[2*k+:2] = 2'(ms[k]);
    return v;
  endfunction

  task automatic report(string tag, logic ok, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic check_inv();
    int no = 0, ns = 0;
    for (int k = 0; k < 4; k++) begin
      if (state[2*k+:2] >= 2) no++;
      if (state[2*k+:2] == 1) ns++;
    end
    report("R9", (no <= 1) && !(no == 1 && ns > 0), $sformatf("%h", state), "single owner");
  endtask

  // model of one operation, from the requirements
  task automatic model(input int r, input bit st, output int eb, output int ek,
                       output int ei, output bit ew, output string tag);
    int own = -1, shr = -1;
    eb = 0; ek = 0; ei = 0; ew = 0;
    for (int k = 3; k >= 0; k--) if (k != r) begin
      if (ms[k] >= 2) own = k;
      if (ms[k] == 1) shr = k;
    end
    if (!st) begin
      if (ms[r] != 0) tag = "R2";
      else begin
        eb = 1;
        if (own >= 0) begin
          tag = "R4"; ek = 2; ei = own; ew = (ms[own] == 3);
          ms[own] = 1; ms[r] = 1;
        end else if (shr >= 0) begin
          tag = "R5"; ek = 2; ei = shr; ms[r] = 1;
        end else begin
          tag = "R3"; ek = 1; ms[r] = 2;
        end
      end
    end else begin
      if (ms[r] == 3) tag = "R6";
      else if (ms[r] == 2) begin tag = "R6"; ms[r] = 3; end
      else begin
        tag = "R7"; eb = 2;
        if (own >= 0) begin ek = 2; ei = own; end
        else if (shr >= 0) begin ek = 2; ei = shr; end
        else ek = 1;
        for (int k = 0; k < 4; k++) ms[k] = 0;
        ms[r] = 3;
      end
    end
  endtask

  task automatic do_op(input int r, input bit st);
    int eb, ek, ei; bit ew; string tag;
    logic [7:0] es;
    model(r, st, eb, ek, ei, ew, tag);
    es = pack_model();
    req_valid = 1'b1; req_id = 2'(r); req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    report(tag, rsp_valid === 1'b1 && bus_op === 2'(eb) && sup_kind === 2'(ek) &&
           sup_id === 2'(ei) && wb === ew && state === es,
           $sformatf("v%b b%0d k%0d i%0d w%b s%h", rsp_valid, bus_op, sup_kind, sup_id, wb, state),
           $sformatf("v1 b%0d k%0d i%0d w%b s%h", eb, ek, ei, ew, es));
    check_inv();
  endtask

  task automatic check_idle();
    logic [7:0] es;
    es = pack_model();
    @(negedge clk);
    report("R8", rsp_valid === 1'b0 && bus_op === 2'd0 && sup_kind === 2'd0 &&
           sup_id === 2'd0 && wb === 1'b0 && state === es,
           $sformatf("v%b b%0d k%0d i%0d w%b s%h", rsp_valid, bus_op, sup_kind, sup_id, wb, state),
           $sformatf("v0 b0 k0 i0 w0 s%h", es));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) ms[k] = 0;
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset();
    report("R1", state === 8'h00 && rsp_valid === 1'b0 && bus_op === 2'd0 &&
           sup_kind === 2'd0 && sup_id === 2'd0 && wb === 1'b0,
           $sformatf("s%h v%b b%0d", state, rsp_valid, bus_op), "all zero");
    // every sequence of four operations from reset
    for (int s = 0; s < 4096; s++) begin
      do_reset();
      for (int j = 0; j < 4; j++) begin
        int op = (s >> (3 * j)) & 7;
        do_op(op & 3, bit'(op >> 2));
      end
      if (s % 64 == 0) check_idle();
    end
    // long pseudo-random run, back-to-back with gaps
    do_reset();
    lfsr = 16'hace1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_op(int'(lfsr[1:0]), lfsr[2]);
      if (lfsr[7:5] == 3'd0) check_idle();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule